// File: doc/BRIEF.md
# Cache line push buffer

This block sits between a data cache controller and a burst-capable memory bus. When a cache miss has to evict a modified line, it starts the burst read of the missing line at once. It does not write the dirty line back first. While that read is in flight, the block copies the victim line out of the cache arrays into a one-line holding buffer. It uses a narrow line read port for this, one beat per cycle. When the last read beat has arrived and the copy is complete, the block issues a write burst from the holding buffer to the victim's line address. It then marks the buffer empty and returns to idle.

A miss whose victim is clean needs no buffer and runs the read burst only. An explicit line push request skips the read and runs only the copy and the write burst. Read beats are forwarded to a fill port with their beat index, so the cache can install the new line as it arrives. A single request handshake accepts one operation at a time. A busy flag covers the whole operation.

Top module: `line_push_buffer`

## Requirements
- R1: Out of reset, `req_ready_o` is 1, and `busy_o`, `rd_req_o`, `wr_req_o`, `wr_valid_o`, `lr_en_o` and `fill_valid_o` are 0.
- R2: A miss request (`req_push_i`=0) raises `rd_req_o` in the cycle after acceptance. `rd_addr_o` is the miss address with its low log2(line bytes) bits cleared. The request and address hold until `rd_ack_i`. No write request precedes this read.
- R3: A request that needs the victim copied (`req_push_i`=1, or a miss with `req_dirty_i`=1) pulses `lr_en_o` on consecutive cycles from the cycle after acceptance, with `lr_beat_o` = 0, 1, 2, 3. The word on `lr_data_i` is taken one cycle after each pulse.
- R4: `wr_req_o` stays low until all four read beats of the same operation have been accepted and the victim copy is complete.
- R5: The write burst goes to the victim's line-aligned address. After `wr_ack_i`, it presents the four copied words in ascending beat order on `wr_data_o`, and each word advances on `wr_ready_i`. The buffer is then emptied and the block returns to idle.
- R6: Each read beat (`rd_valid_i` during the read data phase) appears on the fill port in the same cycle, with `fill_beat_o` counting 0 to 3.
- R7: A miss with `req_dirty_i`=0 produces the read burst only: no line read pulse and no write request.
- R8: A push request (`req_push_i`=1) produces the copy and write burst only, with no read request.
- R9: While an operation is in progress `req_ready_o` is 0, and a pending request is not accepted.
- R10: `busy_o` is high from the cycle after acceptance until the cycle after the final beat of the operation: the last write beat, or the last read beat for a clean miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Operation request |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_push_i | input | 1 | 1: explicit line push, 0: miss |
| req_dirty_i | input | 1 | Miss victim is modified |
| req_addr_i | input | ADDR_W | Miss address |
| req_victim_addr_i | input | ADDR_W | Victim line address |
| lr_en_o | output | 1 | Cache line read strobe |
| lr_beat_o | output | log2(BEATS) | Beat index for line read |
| lr_data_i | input | DATA_W | Cache word, one cycle after strobe |
| fill_valid_o | output | 1 | Fill beat valid |
| fill_beat_o | output | log2(BEATS) | Fill beat index |
| fill_data_o | output | DATA_W | Fill beat data |
| rd_req_o | output | 1 | Read burst request |
| rd_addr_o | output | ADDR_W | Read burst line address |
| rd_ack_i | input | 1 | Read burst accepted |
| rd_valid_i | input | 1 | Read beat valid |
| rd_data_i | input | DATA_W | Read beat data |
| wr_req_o | output | 1 | Write burst request |
| wr_addr_o | output | ADDR_W | Write burst line address |
| wr_ack_i | input | 1 | Write burst accepted |
| wr_valid_o | output | 1 | Write beat valid |
| wr_data_o | output | DATA_W | Write beat data |
| wr_ready_i | input | 1 | Write beat taken |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data, four beats per line, and so a 16-byte line. This makes every beat index, the counter wrap and the 4-bit alignment mask reachable. It sweeps all three operation kinds across several in-line byte offsets, bus acknowledge delays of 0 to 2 cycles, and back-to-back or gapped beats. Under those sweeps the copy finishes before, with, or after the read, which exercises the write-start ordering. A second request is held on the handshake for every operation to test the hold-off.

// File: rtl/lpb_pkg.sv
`timescale 1ns/1ps
package lpb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_DATA,
    ST_WR_REQ,
    ST_WR_DATA
  } lpb_state_e;
endpackage

// File: rtl/lpb_beat_ctr.sv
`timescale 1ns/1ps
module lpb_beat_ctr #(
  parameter int BEATS = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (inc_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/lpb_store.sv
`timescale 1ns/1ps
module lpb_store #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clr_i,
  output logic              lr_en_o,
  output logic [IDX_W-1:0]  lr_beat_o,
  input  logic [DATA_W-1:0] lr_data_i,
  output logic              valid_o,
  input  logic [IDX_W-1:0]  rd_beat_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic             cap_act_q;
  logic [IDX_W-1:0] cap_idx;
  logic             cap_last;
  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic             valid_q;
  logic [DATA_W-1:0] line_q [BEATS];

  lpb_beat_ctr #(.BEATS(BEATS)) i_cap_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .inc_i  (cap_act_q),
    .cnt_o  (cap_idx),
    .last_o (cap_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cap_act_q <= 1'b0;
    else if (start_i)               cap_act_q <= 1'b1;
    else if (cap_act_q && cap_last) cap_act_q <= 1'b0;
  end

  // cache word returns one cycle after the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      pend_q     <= cap_act_q;
      pend_idx_q <= cap_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            valid_q <= 1'b0;
    else if (clr_i)                         valid_q <= 1'b0;
    else if (pend_q && pend_idx_q == LAST)  valid_q <= 1'b1;
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    line_q[g] <= '0;
      else if (pend_q && pend_idx_q == IDX_W'(g))     line_q[g] <= lr_data_i;
    end
  end

  assign lr_en_o   = cap_act_q;
  assign lr_beat_o = cap_idx;
  assign valid_o   = valid_q;
  assign rd_data_o = line_q[rd_beat_i];
endmodule

// File: rtl/line_push_buffer.sv
`timescale 1ns/1ps
module line_push_buffer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_push_i,
  input  logic              req_dirty_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W-1:0] req_victim_addr_i,
  output logic              lr_en_o,
  output logic [IDX_W-1:0]  lr_beat_o,
  input  logic [DATA_W-1:0] lr_data_i,
  output logic              fill_valid_o,
  output logic [IDX_W-1:0]  fill_beat_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  input  logic              wr_ack_i,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              busy_o
);
  import lpb_pkg::*;

  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int OFF_W      = $clog2(BEATS * BEAT_BYTES);

  lpb_state_e state_q, state_d;
  logic [ADDR_W-1:0] miss_line_q, vic_line_q;
  logic              wb_q;
  logic              accept, need_copy;
  logic              rd_beat, wr_beat;
  logic [IDX_W-1:0]  beat_idx;
  logic              beat_last;
  logic              pb_valid;
  logic              pb_clr;
  logic [DATA_W-1:0] pb_data;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign need_copy = req_push_i || req_dirty_i;
  assign rd_beat   = (state_q == ST_RD_DATA) && rd_valid_i;
  assign wr_beat   = (state_q == ST_WR_DATA) && wr_ready_i;
  assign pb_clr    = wr_beat && beat_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = req_push_i ? ST_WR_REQ : ST_RD_REQ;
      ST_RD_REQ:  if (rd_ack_i) state_d = ST_RD_DATA;
      ST_RD_DATA: if (rd_beat && beat_last) state_d = wb_q ? ST_WR_REQ : ST_IDLE;
      ST_WR_REQ:  if (pb_valid && wr_ack_i) state_d = ST_WR_DATA;
      ST_WR_DATA: if (pb_clr) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      miss_line_q <= '0;
      vic_line_q  <= '0;
      wb_q        <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        miss_line_q <= {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        vic_line_q  <= {req_victim_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        wb_q        <= need_copy;
      end
    end
  end

  // read and write bursts never overlap: one counter serves both
  lpb_beat_ctr #(.BEATS(BEATS)) i_beat_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (rd_beat || wr_beat),
    .cnt_o  (beat_idx),
    .last_o (beat_last)
  );

  lpb_store #(.DATA_W(DATA_W), .BEATS(BEATS)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept && need_copy),
    .clr_i     (pb_clr),
    .lr_en_o   (lr_en_o),
    .lr_beat_o (lr_beat_o),
    .lr_data_i (lr_data_i),
    .valid_o   (pb_valid),
    .rd_beat_i (beat_idx),
    .rd_data_o (pb_data)
  );

  assign req_ready_o  = (state_q == ST_IDLE);
  assign busy_o       = (state_q != ST_IDLE);
  assign rd_req_o     = (state_q == ST_RD_REQ);
  assign rd_addr_o    = miss_line_q;
  assign fill_valid_o = rd_beat;
  assign fill_beat_o  = beat_idx;
  assign fill_data_o  = rd_data_i;
  assign wr_req_o     = (state_q == ST_WR_REQ) && pb_valid;
  assign wr_addr_o    = vic_line_q;
  assign wr_valid_o   = (state_q == ST_WR_DATA);
  assign wr_data_o    = pb_data;
endmodule

module lpb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              req_ready_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              rd_valid_i,
  input logic              wr_req_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              wr_valid_o,
  input logic              fill_valid_o,
  input logic              lr_en_o,
  input logic [IDX_W-1:0]  lr_beat_o
);
  localparam int OFF_W = $clog2(BEATS * (DATA_W / 8));

  logic             rd_open_q;
  logic [IDX_W-1:0] rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_open_q <= 1'b0;
      rd_cnt_q  <= '0;
    end else if (rd_req_o && rd_ack_i) begin
      rd_open_q <= 1'b1;
      rd_cnt_q  <= '0;
    end else if (rd_open_q && rd_valid_i) begin
      rd_cnt_q <= rd_cnt_q + 1'b1;
      if (rd_cnt_q == IDX_W'(BEATS - 1)) rd_open_q <= 1'b0;
    end
  end

  // R9
  holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o && !wr_req_o && !wr_valid_o && !fill_valid_o);
  // R2
  rd_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[OFF_W-1:0] == '0);
  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  // R5
  wr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_addr_o[OFF_W-1:0] == '0);
  // R4
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !rd_open_q && !rd_req_o);
  // R6
  fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> rd_valid_i && rd_open_q);
  // R3
  lr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_en_o && $past(lr_en_o) |-> lr_beat_o == $past(lr_beat_o) + 1'b1);
  // R3
  lr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lr_en_o) |-> lr_beat_o == '0);
endmodule

bind line_push_buffer lpb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)
) i_lpb_checker (.*);

// File: tb/test_line_push_buffer.sv
`timescale 1ns/1ps
module test_line_push_buffer;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BEATS  = 4;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_push_i = 1'b0, req_dirty_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0, req_victim_addr_i = '0;
  logic lr_en_o;
  logic [IDX_W-1:0] lr_beat_o;
  logic [DATA_W-1:0] lr_data_i = '0;
  logic fill_valid_o;
  logic [IDX_W-1:0] fill_beat_o;
  logic [DATA_W-1:0] fill_data_o;
  logic rd_req_o, rd_ack_i = 1'b0, rd_valid_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic wr_req_o, wr_ack_i = 1'b0, wr_valid_o, wr_ready_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [DATA_W-1:0] wr_data_o;
  logic req_ready_o, busy_o;

  always #10 clk = ~clk;

  line_push_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) i_line_push_buffer (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_push_i(req_push_i),
    .req_dirty_i(req_dirty_i), .req_addr_i(req_addr_i), .req_victim_addr_i(req_victim_addr_i),
    .lr_en_o(lr_en_o), .lr_beat_o(lr_beat_o), .lr_data_i(lr_data_i),
    .fill_valid_o(fill_valid_o), .fill_beat_o(fill_beat_o), .fill_data_o(fill_data_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_ack_i(wr_ack_i),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_ready_i(wr_ready_i),
    .busy_o(busy_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] line_of(input logic [31:0] a);
    return a & ~32'hF;
  endfunction
  function automatic logic [31:0] vword(input logic [31:0] a, input int b);
    return (line_of(a) + 32'(b * 4)) ^ 32'h5A5A_5A5A;
  endfunction
  function automatic logic [31:0] rword(input logic [31:0] a, input int b);
    return (line_of(a) + 32'(b * 4)) ^ 32'hC3C3_3C3C;
  endfunction

  // per-operation scoreboard
  int kind, ack_dly, gap;
  logic [31:0] miss_a, vic_a;
  bit lr_pend; int lr_pend_beat, cap_seen;
  int rd_wait, rd_acks, rd_sent; bit rd_live;
  int wr_wait, wr_acks, wr_sent;
  int fill_cnt;

  task automatic step();
    @(negedge clk);
    cyc++;
    lr_data_i = lr_pend ? vword(vic_a, lr_pend_beat) : 32'hDEAD_BEEF;
    lr_pend = 1'b0;
    if (lr_en_o) begin
      chk(lr_beat_o == IDX_W'(cap_seen), "R3 line read beat order", 64'(lr_beat_o), 64'(cap_seen));
      lr_pend = 1'b1; lr_pend_beat = int'(lr_beat_o); cap_seen++;
    end
    rd_valid_i = 1'b0; rd_data_i = 32'h0BAD_0BAD;
    if (rd_live && rd_sent < BEATS && (gap == 0 || cyc[0])) begin
      rd_valid_i = 1'b1; rd_data_i = rword(miss_a, rd_sent);
    end
    rd_ack_i = 1'b0;
    if (rd_req_o) begin
      if (rd_wait >= ack_dly) begin
        rd_ack_i = 1'b1; rd_acks++; rd_live = 1'b1; rd_wait = 0;
        chk(rd_addr_o == line_of(miss_a), "R2 read line address", 64'(rd_addr_o), 64'(line_of(miss_a)));
        chk(wr_acks == 0, "R2 read precedes write", 64'(wr_acks), 64'd0);
      end else rd_wait++;
    end
    wr_ack_i = 1'b0;
    if (wr_req_o) begin
      chk(kind == 2 || rd_sent == BEATS, "R4 write waits for read", 64'(rd_sent), 64'(BEATS));
      chk(cap_seen == BEATS && !lr_pend, "R4 write waits for copy", 64'(cap_seen), 64'(BEATS));
      if (wr_wait >= ack_dly) begin
        wr_ack_i = 1'b1; wr_acks++; wr_wait = 0;
        chk(wr_addr_o == line_of(vic_a), "R5 write line address", 64'(wr_addr_o), 64'(line_of(vic_a)));
      end else wr_wait++;
    end
    wr_ready_i = 1'b0;
    if (wr_valid_o && (gap == 0 || cyc[0])) begin
      wr_ready_i = 1'b1;
      chk(wr_data_o == vword(vic_a, wr_sent), "R5 write beat data", 64'(wr_data_o), 64'(vword(vic_a, wr_sent)));
      wr_sent++;
    end
    #2;
    if (fill_valid_o) begin
      chk(fill_beat_o == IDX_W'(fill_cnt), "R6 fill beat index", 64'(fill_beat_o), 64'(fill_cnt));
      chk(fill_data_o == rword(miss_a, fill_cnt), "R6 fill data", 64'(fill_data_o), 64'(rword(miss_a, fill_cnt)));
      fill_cnt++;
    end
    if (rd_valid_i) begin
      rd_sent++;
      if (rd_sent == BEATS) rd_live = 1'b0;
    end
  endtask

  task automatic run_op(input int k, input logic [31:0] m, input logic [31:0] v);
    int guard;
    kind = k; miss_a = m; vic_a = v;
    lr_pend = 0; cap_seen = 0; rd_wait = 0; rd_acks = 0; rd_sent = 0; rd_live = 0;
    wr_wait = 0; wr_acks = 0; wr_sent = 0; fill_cnt = 0;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R9 ready when idle", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_push_i = (k == 2); req_dirty_i = (k != 0);
    req_addr_i = m; req_victim_addr_i = v;
    step();
    chk(busy_o == 1'b1, "R10 busy after accept", 64'(busy_o), 64'd1);
    // decoy request held on the handshake while busy
    req_push_i = 1'b0; req_dirty_i = 1'b1;
    req_addr_i = 32'hFFFF_FFF0; req_victim_addr_i = 32'hEEEE_EEE0;
    guard = 0;
    while (busy_o && guard < 200) begin
      chk(req_ready_o == 1'b0, "R9 hold-off while busy", 64'(req_ready_o), 64'd0);
      step();
      guard++;
      if (!busy_o) req_valid_i = 1'b0;
    end
    req_valid_i = 1'b0;
    chk(guard < 200, "R10 operation completes", 64'(guard), 64'd200);
    chk(rd_acks == (k != 2 ? 1 : 0), k == 2 ? "R8 push issues no read" : "R2 one read burst",
        64'(rd_acks), 64'(k != 2 ? 1 : 0));
    chk(fill_cnt == (k != 2 ? BEATS : 0), "R6 fill beat count", 64'(fill_cnt), 64'(k != 2 ? BEATS : 0));
    chk(cap_seen == (k != 0 ? BEATS : 0), k == 0 ? "R7 clean miss no copy" : "R3 copy beat count",
        64'(cap_seen), 64'(k != 0 ? BEATS : 0));
    chk(wr_acks == (k != 0 ? 1 : 0), k == 0 ? "R7 clean miss no write" : "R8 one write burst",
        64'(wr_acks), 64'(k != 0 ? 1 : 0));
    chk(wr_sent == (k != 0 ? BEATS : 0), "R10 busy drops after final write beat",
        64'(wr_sent), 64'(k != 0 ? BEATS : 0));
    // one idle cycle: no stray activity after the buffer is emptied
    step();
    chk(!busy_o && !rd_req_o && !wr_req_o && rd_acks + wr_acks == (k == 1 ? 2 : 1),
        "R5 buffer emptied, no further bursts", 64'(rd_acks + wr_acks), 64'(k == 1 ? 2 : 1));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int op;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready_o && !busy_o && !rd_req_o && !wr_req_o && !wr_valid_o && !lr_en_o && !fill_valid_o,
        "R1 reset outputs", {58'd0, req_ready_o, busy_o, rd_req_o, wr_req_o, wr_valid_o, lr_en_o}, 64'h20);
    rst_ni = 1'b1;
    op = 0;
    for (int k = 0; k < 3; k++)
      for (int off = 0; off < 16; off += 5)
        for (int d = 0; d < 3; d++)
          for (int g = 0; g < 2; g++) begin
            ack_dly = d; gap = g;
            run_op(k, 32'h1000_0000 + 32'(op * 32'h40) + 32'(off),
                      32'h2000_0000 + 32'(op * 32'h40) + 32'(15 - off));
            op++;
          end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule